// File: doc/BRIEF.md
# Saturating Packed Arithmetic Element

This block is the execution core of a small stream-processing element. It runs a looping program of up to sixteen 40-bit instruction words. Each word chooses an arithmetic or logic operation on 16-bit two's-complement data, where the operands come from the input streams, an accumulator or an immediate. The same word can update the accumulator and the output register in the same cycle. Addition and subtraction can wrap or saturate. A packed mode splits the word into two independent 8-bit lanes.

Several elements can be chained into a 32-bit or 64-bit datapath. A combinational carry passes from each element's `cas_co` to the next element's `cas_ci`. Only the element flagged as the most significant one in the chain clamps on overflow and reports signed overflow. The lower elements pass their carry on and wrap.

A program is written through the load port, one word per cycle. A commit strobe then starts execution at word 0. Any further write stops execution until the next commit.

Top module: `pkd_dsp_core`

## Requirements
- R1: After reset `result` and `ovf` are 0, `pc` is 0 and `running` is 0.
- R2: A cycle with `prog_we` high clears the loaded state, and `prog_commit` sets it. While `running` is low, the sequencer holds `pc`, and `result`, `ovf` and the accumulator keep their values.
- R3: A commit restarts the program at word 0. Each running cycle executes the word at `pc` and advances `pc` by one, wrapping from 15 to 0.
- R4: The opcode in bits [39:36] selects the operation: 0 add, 1 subtract (a + ~b + carry), 2 AND, 3 OR, 4 XOR, 5 pass A. Without saturation, add and subtract wrap modulo 2^16.
- R5: With saturate (bit 35) and chain-top (bit 32) both set in 16-bit mode, a signed overflow clamps the result to 0x7FFF (positive overflow) or 0x8000 (negative overflow). When top is set, `ovf` reports signed overflow whether or not saturation is selected.
- R6: When chain-top is clear in 16-bit mode, add and subtract never clamp and `ovf` reads 0.
- R7: `cas_co` is the combinational carry out of bit 15 for the current add or subtract. It is 0 for logic ops and in packed mode. With carry-select (bit 33) set, `cas_ci` replaces the default carry-in (0 for add, 1 for subtract).
- R8: With packed (bit 34) set, add and subtract work on two 8-bit lanes, and no carry crosses from bit 7 to bit 8. With saturate set, each lane clamps on its own to 0x7F or 0x80, and `ovf` is the OR of the lane overflows.
- R9: Bit 31 selects operand A from the accumulator instead of `a_in`. Bit 30 selects operand B from the immediate in bits [15:0] instead of `b_in`. Bits 29 and 28 write the result to the accumulator and to `result`/`ovf` in the same cycle. When bit 28 is clear, `result` and `ovf` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Write one program word |
| prog_addr | input | 4 | Program word address |
| prog_data | input | 40 | Program word |
| prog_commit | input | 1 | Start the program at word 0 |
| a_in | input | 16 | Stream operand A |
| b_in | input | 16 | Stream operand B |
| cas_ci | input | 1 | Carry in from the less significant element |
| cas_co | output | 1 | Carry out to the more significant element |
| result | output | 16 | Registered result |
| ovf | output | 1 | Registered overflow flag |
| running | output | 1 | Program loaded and executing |
| pc | output | 4 | Program counter |

## Verification
The bench builds the element with its default 16-bit word and 8-bit lanes, and a 16-word, 4-bit-addressed store. That store makes the 15-to-0 program-counter wrap reachable in one short program. Both lanes of the packed mode are exercised with carries and overflows placed at the lane boundary. A single element is tested in both chain positions by toggling the chain-top bit. It is also tested with the external carry driven directly, so the low-word and high-word roles of a cascade are both covered.

// File: rtl/pkd_dsp_pkg.sv
package pkd_dsp_pkg;

  localparam int DW    = 16;
  localparam int LW    = 8;
  localparam int NL    = DW / LW;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = 40;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_PASS = 4'd5
  } op_e;

  typedef struct packed {
    logic [3:0]  op;
    logic        sat;
    logic        pk;
    logic        csel;
    logic        top;
    logic        asel;
    logic        bsel;
    logic        wacc;
    logic        wout;
    logic [11:0] rsvd;
    logic [15:0] imm;
  } instr_t;

endpackage

// File: rtl/pkd_imem.sv
module pkd_imem
  import pkd_dsp_pkg::*;
#(
  parameter int DEPTH_P = DEPTH,
  parameter int WIDTH_P = IW,
  localparam int AW_L   = $clog2(DEPTH_P)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW_L-1:0]    waddr,
  input  logic [WIDTH_P-1:0] wdata,
  input  logic               commit,
  input  logic [AW_L-1:0]    raddr,
  output logic [WIDTH_P-1:0] rdata,
  output logic               loaded
);

  logic [WIDTH_P-1:0] mem [DEPTH_P];
  logic               loaded_d;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    loaded_d = loaded;
    if (commit) loaded_d = 1'b1;
    if (we)     loaded_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loaded <= 1'b0;
    else        loaded <= loaded_d;
  end

  assign rdata = mem[raddr];

  a_r2_we_clears : assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !loaded);

endmodule

// File: rtl/pkd_seq.sv
module pkd_seq #(
  parameter int AW_P = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            adv,
  output logic [AW_P-1:0] pc
);

  logic [AW_P-1:0] pc_d;

  always_comb begin
    pc_d = pc;
    if (restart)  pc_d = '0;
    else if (adv) pc_d = pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_d;
  end

  a_r3_pc_step : assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart) |=> pc == AW_P'($past(pc) + 1'b1));
  a_r3_restart : assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pc == '0);
  a_r2_pc_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(pc));

endmodule

// File: rtl/pkd_alu.sv
module pkd_alu
  import pkd_dsp_pkg::*;
#(
  parameter int DW_P = DW,
  parameter int LW_P = LW,
  localparam int NL_L = DW_P / LW_P
) (
  input  logic [3:0]      op,
  input  logic            sat,
  input  logic            pk,
  input  logic            csel,
  input  logic            top,
  input  logic [DW_P-1:0] a,
  input  logic [DW_P-1:0] b,
  input  logic            ci,
  output logic [DW_P-1:0] res,
  output logic            ovf,
  output logic            co
);

  localparam logic [DW_P-1:0] WMAX = {1'b0, {(DW_P-1){1'b1}}};
  localparam logic [DW_P-1:0] WMIN = {1'b1, {(DW_P-1){1'b0}}};
  localparam logic [LW_P-1:0] LMAX = {1'b0, {(LW_P-1){1'b1}}};
  localparam logic [LW_P-1:0] LMIN = {1'b1, {(LW_P-1){1'b0}}};

  logic            is_sub, is_arith;
  logic [DW_P-1:0] bx;
  logic            c0;
  logic [DW_P:0]   wsum;
  logic            wovf;
  logic [DW_P-1:0] wres;
  logic [DW_P-1:0] pres;
  logic [NL_L-1:0] lovf;
  logic [DW_P-1:0] lres;

  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign bx       = is_sub ? ~b : b;
  assign c0       = csel ? ci : is_sub;

  // full-width path
  assign wsum = {1'b0, a} + {1'b0, bx} + {{DW_P{1'b0}}, c0};
  assign wovf = (a[DW_P-1] == bx[DW_P-1]) && (wsum[DW_P-1] != a[DW_P-1]);

  always_comb begin
    wres = wsum[DW_P-1:0];
    if (top && sat && wovf) wres = a[DW_P-1] ? WMIN : WMAX;
  end

  // packed lanes, each with its own carry-in
  for (genvar l = 0; l < NL_L; l++) begin : g_lane
    logic [LW_P-1:0] la, lb;
    logic [LW_P:0]   ls;
    logic            lo;
    assign la = a[l*LW_P +: LW_P];
    assign lb = bx[l*LW_P +: LW_P];
    assign ls = {1'b0, la} + {1'b0, lb} + {{LW_P{1'b0}}, is_sub};
    assign lo = (la[LW_P-1] == lb[LW_P-1]) && (ls[LW_P-1] != la[LW_P-1]);
    assign lovf[l] = lo;
    assign pres[l*LW_P +: LW_P] =
      (sat && lo) ? (la[LW_P-1] ? LMIN : LMAX) : ls[LW_P-1:0];
  end

  assign lres = pres;

  always_comb begin
    res = a;
    ovf = 1'b0;
    co  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        if (pk) begin
          res = lres;
          ovf = |lovf;
        end else begin
          res = wres;
          ovf = top && wovf;
          co  = wsum[DW_P];
        end
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a;
    endcase
  end

  a_r7_logic_no_carry : assert property (@(op) !is_arith |-> !co);

endmodule

// File: rtl/pkd_dsp_core.sv
module pkd_dsp_core
  import pkd_dsp_pkg::*;
#(
  parameter int DW_P    = DW,
  parameter int LW_P    = LW,
  parameter int DEPTH_P = DEPTH,
  localparam int AW_L   = $clog2(DEPTH_P)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [AW_L-1:0] prog_addr,
  input  logic [IW-1:0]   prog_data,
  input  logic            prog_commit,
  input  logic [DW_P-1:0] a_in,
  input  logic [DW_P-1:0] b_in,
  input  logic            cas_ci,
  output logic            cas_co,
  output logic [DW_P-1:0] result,
  output logic            ovf,
  output logic            running,
  output logic [AW_L-1:0] pc
);

  // asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_ni = rsync[1];

  logic [IW-1:0]   iword;
  instr_t          ins;
  logic            loaded;
  logic            exec;
  logic [DW_P-1:0] acc_q, acc_d, out_d;
  logic            ovf_d;
  logic [DW_P-1:0] opa, opb, alu_res;
  logic            alu_ovf;

  pkd_imem #(.DEPTH_P(DEPTH_P), .WIDTH_P(IW)) u_imem (
    .clk   (clk),
    .rst_n (rst_ni),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .commit(prog_commit),
    .raddr (pc),
    .rdata (iword),
    .loaded(loaded)
  );

  assign exec    = loaded && !prog_we;
  assign running = exec;

  pkd_seq #(.AW_P(AW_L)) u_seq (
    .clk    (clk),
    .rst_n  (rst_ni),
    .restart(prog_commit && !prog_we),
    .adv    (exec),
    .pc     (pc)
  );

  assign ins = instr_t'(iword);
  assign opa = ins.asel ? acc_q : a_in;
  assign opb = ins.bsel ? ins.imm[DW_P-1:0] : b_in;

  pkd_alu #(.DW_P(DW_P), .LW_P(LW_P)) u_alu (
    .op  (ins.op),
    .sat (ins.sat),
    .pk  (ins.pk),
    .csel(ins.csel),
    .top (ins.top),
    .a   (opa),
    .b   (opb),
    .ci  (cas_ci),
    .res (alu_res),
    .ovf (alu_ovf),
    .co  (cas_co)
  );

  always_comb begin
    acc_d = acc_q;
    out_d = result;
    ovf_d = ovf;
    if (exec && ins.wacc) acc_d = alu_res;
    if (exec && ins.wout) begin
      out_d = alu_res;
      ovf_d = alu_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      result <= out_d;
      ovf    <= ovf_d;
    end
  end

  a_r2_idle_hold : assert property (@(posedge clk) disable iff (!rst_ni)
    !exec |=> $stable(result) && $stable(acc_q) && $stable(ovf));
  a_r9_out_hold : assert property (@(posedge clk) disable iff (!rst_ni)
    (exec && !ins.wout) |=> $stable(result) && $stable(ovf));
  a_r6_nontop_quiet : assert property (@(posedge clk) disable iff (!rst_ni)
    (exec && ins.wout && !ins.top && !ins.pk) |=> !ovf);
  a_r5_clamp_value : assert property (@(posedge clk) disable iff (!rst_ni)
    (exec && ins.wout && ins.top && ins.sat && !ins.pk && alu_ovf)
      |=> (result == {1'b0, {(DW_P-1){1'b1}}}) || (result == {1'b1, {(DW_P-1){1'b0}}}));

endmodule

// File: tb/tb_pkd_dsp_core.sv
module tb_pkd_dsp_core;

  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] F_SAT = 8'h80, F_PK = 8'h40, F_CS = 8'h20, F_TOP = 8'h10;
  localparam logic [7:0] F_ASEL = 8'h08, F_BSEL = 8'h04, F_WACC = 8'h02, F_WOUT = 8'h01;

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  fl;
    logic [15:0] imm;
    logic [15:0] a;
    logic [15:0] b;
    logic        ci;
    logic [15:0] exp;
    logic        eovf;
    logic        eco;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 8'h11, 16'h0, 16'h1234, 16'h1111, 1'b0, 16'h2345, 1'b0, 1'b0, 4'd4}, // R4 add
    '{4'd0, 8'h91, 16'h0, 16'h7000, 16'h1000, 1'b0, 16'h7FFF, 1'b1, 1'b0, 4'd5}, // R5 pos clamp
    '{4'd0, 8'h11, 16'h0, 16'h7000, 16'h1000, 1'b0, 16'h8000, 1'b1, 1'b0, 4'd5}, // R5 wrap+flag
    '{4'd0, 8'h91, 16'h0, 16'h8000, 16'hFFFF, 1'b0, 16'h8000, 1'b1, 1'b1, 4'd5}, // R5 neg clamp
    '{4'd0, 8'h81, 16'h0, 16'h7000, 16'h1000, 1'b0, 16'h8000, 1'b0, 1'b0, 4'd6}, // R6 non-top
    '{4'd1, 8'h91, 16'h0, 16'h8000, 16'h0001, 1'b0, 16'h8000, 1'b1, 1'b1, 4'd5}, // R5 sub clamp
    '{4'd1, 8'h11, 16'h0, 16'h0005, 16'h0007, 1'b0, 16'hFFFE, 1'b0, 1'b0, 4'd4}, // R4 sub
    '{4'd0, 8'hC1, 16'h0, 16'h7F01, 16'h01FF, 1'b0, 16'h7F00, 1'b1, 1'b0, 4'd8}, // R8 lane sat
    '{4'd0, 8'h41, 16'h0, 16'h00FF, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd8}, // R8 no cross
    '{4'd1, 8'hC1, 16'h0, 16'h8010, 16'h0120, 1'b0, 16'h80F0, 1'b1, 1'b0, 4'd8}, // R8 sub lanes
    '{4'd0, 8'h31, 16'h0, 16'h0001, 16'h0001, 1'b1, 16'h0003, 1'b0, 1'b0, 4'd7}, // R7 ci add
    '{4'd1, 8'h31, 16'h0, 16'h0005, 16'h0003, 1'b0, 16'h0001, 1'b0, 1'b1, 4'd7}, // R7 ci sub
    '{4'd2, 8'h11, 16'h0, 16'hF0F0, 16'hFF00, 1'b0, 16'hF000, 1'b0, 1'b0, 4'd4}, // R4 and
    '{4'd3, 8'h11, 16'h0, 16'hF0F0, 16'h0F0F, 1'b0, 16'hFFFF, 1'b0, 1'b0, 4'd4}, // R4 or
    '{4'd4, 8'h11, 16'h0, 16'hFFFF, 16'h0F0F, 1'b0, 16'hF0F0, 1'b0, 1'b0, 4'd4}, // R4 xor
    '{4'd5, 8'h11, 16'h0, 16'h1357, 16'hAAAA, 1'b0, 16'h1357, 1'b0, 1'b0, 4'd4}, // R4 pass
    '{4'd0, 8'h15, 16'h0023, 16'h0100, 16'hFFFF, 1'b0, 16'h0123, 1'b0, 1'b0, 4'd9}, // R9 imm
    '{4'd0, 8'h01, 16'h0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd7}  // R7 low element
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we, prog_commit, cas_ci;
  logic [3:0]  prog_addr;
  logic [39:0] prog_data;
  logic [15:0] a_in, b_in;
  logic        cas_co, ovf, running;
  logic [15:0] result;
  logic [3:0]  pc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkd_dsp_core dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_commit(prog_commit), .a_in(a_in), .b_in(b_in),
    .cas_ci(cas_ci), .cas_co(cas_co), .result(result), .ovf(ovf),
    .running(running), .pc(pc)
  );

  function automatic logic [39:0] mk(logic [3:0] op, logic [7:0] fl, logic [15:0] imm);
    return {op, fl, 12'h000, imm};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_word(logic [3:0] ad, logic [39:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = ad; prog_data = w;
    @(posedge clk);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    prog_commit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    prog_commit = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_commit = 1'b0; prog_addr = '0;
    prog_data = '0; a_in = '0; b_in = '0; cas_ci = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 result", result, 16'h0);
    chk("R1 ovf", {15'h0, ovf}, 16'h0);
    chk("R1 pc", {12'h0, pc}, 16'h0);
    chk("R1 running", {15'h0, running}, 16'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 16; k++) write_word(4'(k), mk(VEC[v].op, VEC[v].fl, VEC[v].imm));
      a_in = VEC[v].a; b_in = VEC[v].b; cas_ci = VEC[v].ci;
      commit();
      chk($sformatf("R%0d vec%0d cas_co", VEC[v].rq, v), {15'h0, cas_co}, {15'h0, VEC[v].eco});
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", VEC[v].rq, v), result, VEC[v].exp);
      chk($sformatf("R%0d vec%0d ovf", VEC[v].rq, v), {15'h0, ovf}, {15'h0, VEC[v].eovf});
    end

    // R3 sequencing and wrap: word k yields 3k+1
    for (int k = 0; k < 16; k++) write_word(4'(k), mk(4'd0, F_TOP | F_BSEL | F_WOUT, 16'(3*k+1)));
    a_in = 16'h0;
    commit();
    chk("R3 restart pc", {12'h0, pc}, 16'h0);
    for (int j = 0; j < 17; j++) begin
      @(negedge clk);
      chk($sformatf("R3 step%0d result", j), result, 16'(3*(j%16)+1));
      chk($sformatf("R3 step%0d pc", j), {12'h0, pc}, 16'((j+1)%16));
    end

    // R2 idle: a write stops execution, result and pc hold
    write_word(4'd0, mk(4'd0, F_TOP | F_BSEL | F_WOUT, 16'h5555));
    begin
      logic [15:0] r0; logic [3:0] p0;
      r0 = result; p0 = pc;
      repeat (4) @(negedge clk);
      chk("R2 not running", {15'h0, running}, 16'h0);
      chk("R2 result held", result, r0);
      chk("R2 pc held", {12'h0, pc}, {12'h0, p0});
    end

    // R9 accumulator with saturation, R5 on accumulated value
    do_reset();
    for (int k = 0; k < 16; k++)
      write_word(4'(k), mk(4'd0, F_SAT | F_TOP | F_ASEL | F_BSEL | F_WACC | F_WOUT, 16'h3000));
    commit();
    @(negedge clk); chk("R9 acc1", result, 16'h3000); chk("R9 acc1 ovf", {15'h0, ovf}, 16'h0);
    @(negedge clk); chk("R9 acc2", result, 16'h6000);
    @(negedge clk); chk("R5 acc clamp", result, 16'h7FFF); chk("R5 acc ovf", {15'h0, ovf}, 16'h1);
    @(negedge clk); chk("R5 acc stays", result, 16'h7FFF);

    // R9 result not written when output-write bit clear; acc still written
    do_reset();
    write_word(4'd0, mk(4'd0, F_TOP | F_BSEL | F_WOUT, 16'h0042));
    for (int k = 1; k < 16; k++) write_word(4'(k), mk(4'd0, F_TOP | F_BSEL | F_WACC, 16'h0777));
    write_word(4'd15, mk(4'd0, F_TOP | F_ASEL | F_BSEL | F_WOUT, 16'h0001));
    a_in = 16'h0;
    commit();
    @(negedge clk); chk("R9 first write", result, 16'h0042);
    repeat (14) @(negedge clk);
    chk("R9 no out write", result, 16'h0042);
    @(negedge clk); chk("R9 acc then out", result, 16'h0778);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule